// File: doc/BRIEF.md
# Prioritized Interrupt and Status-Word Unit

This unit owns the processor status word (a 32-bit register) and decides when the core must leave its normal flow for a handler. Sixteen request lines arrive from peripherals. Each line is gated by its own enable bit in the status word. A global enable flag then gates the whole set. From the open requests the unit names the highest-numbered one and raises a trigger. It also presents the start address of the handler the core should jump to.

The surrounding state machine drives four strobes: take-interrupt, take-exception (with a 4-bit cause), return-from-exception, and a full-word write. On entry the unit records why the handler was entered in a 5-bit priority field. It also shifts the enable and user-mode flags into 3-deep stacks so that nested entries can be unwound. A return shifts the stacks back. The trigger is combinational from the stored word, so a new word acts on the trigger one cycle after it is written.

Top module: `irq_psw_unit`

## Requirements
- R1: After reset the status word is 0, the trigger is 0 and the request number is 0.
- R2: The trigger is 1 exactly when some request bit is set, its mask bit (status bits 15..0, bit i for line i) is set, and the current enable flag (status bit 24) is set.
- R3: The request number is the highest index i with both request bit i and mask bit i set. It is 0 when no such line exists. It does not depend on the enable flag.
- R4: A write stores the data word in the next cycle, with bits 31..28 forced to 0. Bits 31..28 of the status word always read 0.
- R5: Taking an interrupt sets status bits 20..16 to {0, request number} and leaves the mask and the vector-base flag unchanged.
- R6: Taking an exception sets status bits 20..16 to {1, cause}.
- R7: On any entry, both stacks push. The user-mode stack is bits 21 (current), 22 (previous) and 23 (oldest). The enable stack is bits 24, 25 and 26 in the same order. On a push, oldest takes previous, previous takes current, and current becomes 0.
- R8: A return pops both stacks. Current takes previous, previous takes oldest, and oldest keeps its value. The priority field and the mask are unchanged.
- R9: The handler address is 0xE0000000 when bit 27 is 0 and 0xC0000000 when it is 1. The address is plus 8 when the user-miss input is 1 and plus 4 otherwise.
- R10: When strobes coincide, exception beats interrupt, interrupt beats return, and return beats write.
- R11: With no strobe active, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 16 | Interrupt request lines |
| pswWrEn | input | 1 | Full-word status write strobe |
| pswWrData | input | 32 | Status write data |
| takeIrq | input | 1 | Enter an interrupt handler |
| takeExc | input | 1 | Enter an exception handler |
| excCause | input | 4 | Exception cause number |
| retExc | input | 1 | Return from handler |
| userMiss | input | 1 | Select the user-miss handler address |
| psw | output | 32 | Current status word |
| irqTrigger | output | 1 | An enabled, unmasked request is pending |
| irqNum | output | 4 | Highest pending unmasked request |
| handlerAddr | output | 32 | Handler start address |

## Verification
The bench builds the unit with its default parameters: 16 request lines and 3-deep stacks. These defaults put every field at the bit positions stated in the requirements, so the expected status words can be written as literal hex values. With all mask bits open, a walk over every request line reaches each output code of the priority encoder. A run of entries followed by returns drives the stacks to full depth and back, which exposes the refill of the oldest position.

// File: rtl/irq_psw_pkg.sv
package irq_psw_pkg;
  typedef struct packed {
    logic doEntry;
    logic entryExc;
    logic doRet;
    logic doWrite;
  } pswCmd_t;
endpackage

// File: rtl/irq_psw_ctrl.sv
module irq_psw_ctrl
  import irq_psw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    takeIrq,
  input  logic    takeExc,
  input  logic    retExc,
  input  logic    pswWrEn,
  output pswCmd_t cmd
);
  // Fixed precedence: exception, interrupt, return, write.
  always_comb begin
    cmd = '0;
    if (takeExc) begin
      cmd.doEntry  = 1'b1;
      cmd.entryExc = 1'b1;
    end else if (takeIrq) begin
      cmd.doEntry = 1'b1;
    end else if (retExc) begin
      cmd.doRet = 1'b1;
    end else if (pswWrEn) begin
      cmd.doWrite = 1'b1;
    end
  end

  // R10
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> (cmd.doEntry && cmd.entryExc && !cmd.doRet && !cmd.doWrite));

  // R10
  ret_over_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retExc && pswWrEn && !takeIrq && !takeExc) |-> (cmd.doRet && !cmd.doWrite));
endmodule

// File: rtl/irq_psw_datapath.sv
module irq_psw_datapath
  import irq_psw_pkg::*;
#(
  parameter int          NUM_IRQ  = 16,
  parameter int          STACK_D  = 3,
  parameter logic [31:0] BASE_CLR = 32'hE000_0000,
  parameter logic [31:0] BASE_SET = 32'hC000_0000,
  parameter logic [31:0] OFF_GEN  = 32'd4,
  parameter logic [31:0] OFF_MISS = 32'd8,
  localparam int NUM_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  pswCmd_t            cmd,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_W-1:0]   excCause,
  input  logic [31:0]        wrData,
  input  logic               userMiss,
  output logic [31:0]        pswQ,
  output logic               irqTrigger,
  output logic [NUM_W-1:0]   irqNum,
  output logic [31:0]        handlerAddr
);
  localparam int PRIO_W  = NUM_W + 1;
  localparam int PRIO_LO = NUM_IRQ;
  localparam int UM_LO   = PRIO_LO + PRIO_W;
  localparam int IE_LO   = UM_LO + STACK_D;
  localparam int VB_BIT  = IE_LO + STACK_D;
  localparam int USED_W  = VB_BIT + 1;
  localparam logic [31:0] USED_MASK = 32'((64'd1 << USED_W) - 64'd1);

  logic [31:0]        pswD;
  logic [NUM_IRQ-1:0] pending;

  assign pending = irqReq & pswQ[NUM_IRQ-1:0];

  always_comb begin
    irqNum = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pending[i]) irqNum = NUM_W'(i);
    end
  end

  assign irqTrigger  = (|pending) & pswQ[IE_LO];
  assign handlerAddr = (pswQ[VB_BIT] ? BASE_SET : BASE_CLR) + (userMiss ? OFF_MISS : OFF_GEN);

  always_comb begin
    pswD = pswQ;
    if (cmd.doEntry) begin
      pswD[PRIO_LO +: PRIO_W]  = cmd.entryExc ? {1'b1, excCause} : {1'b0, irqNum};
      pswD[UM_LO +: STACK_D]   = {pswQ[UM_LO +: STACK_D-1], 1'b0};
      pswD[IE_LO +: STACK_D]   = {pswQ[IE_LO +: STACK_D-1], 1'b0};
    end else if (cmd.doRet) begin
      pswD[UM_LO +: STACK_D]   = {pswQ[UM_LO+STACK_D-1], pswQ[UM_LO+1 +: STACK_D-1]};
      pswD[IE_LO +: STACK_D]   = {pswQ[IE_LO+STACK_D-1], pswQ[IE_LO+1 +: STACK_D-1]};
    end else if (cmd.doWrite) begin
      pswD = wrData & USED_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pswQ <= '0;
    else       pswQ <= pswD;
  end

  // R7
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doEntry |=> (!pswQ[IE_LO] && !pswQ[UM_LO]));

  // R7
  entry_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doEntry |=> (pswQ[IE_LO+1] == $past(pswQ[IE_LO]) && pswQ[UM_LO+1] == $past(pswQ[UM_LO])));

  // R8
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doRet |=> (pswQ[IE_LO] == $past(pswQ[IE_LO+1]) && pswQ[UM_LO] == $past(pswQ[UM_LO+1])
                   && $stable(pswQ[PRIO_LO +: PRIO_W])));

  // R6
  exc_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.doEntry && cmd.entryExc) |=> pswQ[PRIO_LO+PRIO_W-1]);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.doEntry || cmd.doRet || cmd.doWrite) |=> $stable(pswQ));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pswQ[31:USED_W] == '0);
endmodule

// File: rtl/irq_psw_unit.sv
module irq_psw_unit
  import irq_psw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] irqReq,
  input  logic        pswWrEn,
  input  logic [31:0] pswWrData,
  input  logic        takeIrq,
  input  logic        takeExc,
  input  logic [3:0]  excCause,
  input  logic        retExc,
  input  logic        userMiss,
  output logic [31:0] psw,
  output logic        irqTrigger,
  output logic [3:0]  irqNum,
  output logic [31:0] handlerAddr
);
  pswCmd_t cmd;

  irq_psw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .takeIrq(takeIrq), .takeExc(takeExc),
    .retExc(retExc), .pswWrEn(pswWrEn), .cmd(cmd)
  );

  irq_psw_datapath #(.NUM_IRQ(16), .STACK_D(3)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .irqReq(irqReq), .excCause(excCause),
    .wrData(pswWrData), .userMiss(userMiss), .pswQ(psw), .irqTrigger(irqTrigger),
    .irqNum(irqNum), .handlerAddr(handlerAddr)
  );
endmodule

// File: tb/irq_psw_unit_tb_top.sv
module irq_psw_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] irqReq;
  logic        pswWrEn;
  logic [31:0] pswWrData;
  logic        takeIrq;
  logic        takeExc;
  logic [3:0]  excCause;
  logic        retExc;
  logic        userMiss;
  logic [31:0] psw;
  logic        irqTrigger;
  logic [3:0]  irqNum;
  logic [31:0] handlerAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irq_psw_unit dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .takeIrq(takeIrq), .takeExc(takeExc), .excCause(excCause), .retExc(retExc),
    .userMiss(userMiss), .psw(psw), .irqTrigger(irqTrigger), .irqNum(irqNum),
    .handlerAddr(handlerAddr)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        ti;
    logic        te;
    logic [3:0]  cause;
    logic        rt;
    logic [15:0] req;
    logic        um;
    logic [31:0] expPsw;
    logic        expTrig;
    logic [3:0]  expNum;
    logic [31:0] expAddr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R4 write with reserved bits set; R2 trigger open
    '{1'b1, 32'hF500_80F0, 1'b0, 1'b0, 4'h0, 1'b0, 16'h0030, 1'b0, 32'h0500_80F0, 1'b1, 4'd5, 32'hE000_0004},
    // R5 R7 interrupt entry
    '{1'b0, 32'h0,         1'b1, 1'b0, 4'h0, 1'b0, 16'h0030, 1'b0, 32'h0205_80F0, 1'b0, 4'd5, 32'hE000_0004},
    // R6 R7 exception entry; R9 user miss
    '{1'b0, 32'h0,         1'b0, 1'b1, 4'hA, 1'b0, 16'h8001, 1'b1, 32'h041A_80F0, 1'b0, 4'd15, 32'hE000_0008},
    // R8 return
    '{1'b0, 32'h0,         1'b0, 1'b0, 4'h0, 1'b1, 16'h8001, 1'b0, 32'h061A_80F0, 1'b0, 4'd15, 32'hE000_0004},
    // R8 second return, oldest refills
    '{1'b0, 32'h0,         1'b0, 1'b0, 4'h0, 1'b1, 16'h8001, 1'b0, 32'h071A_80F0, 1'b1, 4'd15, 32'hE000_0004},
    // R11 idle; R3 no request
    '{1'b0, 32'h0,         1'b0, 1'b0, 4'h0, 1'b0, 16'h0000, 1'b0, 32'h071A_80F0, 1'b0, 4'd0, 32'hE000_0004},
    // R9 vector-base set; R2 enable off
    '{1'b1, 32'h08E0_0003, 1'b0, 1'b0, 4'h0, 1'b0, 16'h0002, 1'b1, 32'h08E0_0003, 1'b0, 4'd1, 32'hC000_0008},
    // R10 all strobes, exception wins
    '{1'b1, 32'h0000_0000, 1'b1, 1'b1, 4'h3, 1'b1, 16'h0002, 1'b0, 32'h08D3_0003, 1'b0, 4'd1, 32'hC000_0004},
    // R10 interrupt beats return
    '{1'b0, 32'h0,         1'b1, 1'b0, 4'h0, 1'b1, 16'h0002, 1'b0, 32'h0881_0003, 1'b0, 4'd1, 32'hC000_0004},
    // R10 return beats write
    '{1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 4'h0, 1'b1, 16'h0002, 1'b0, 32'h08C1_0003, 1'b0, 4'd1, 32'hC000_0004}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    pswWrEn = 1'b0; pswWrData = '0; takeIrq = 1'b0; takeExc = 1'b0;
    excCause = '0; retExc = 1'b0; userMiss = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqReq = '0; idleIn();
    repeat (3) @(posedge clk);
    #2;
    check("R1 psw", psw, 32'h0);
    check("R1 trigger", {31'b0, irqTrigger}, 32'h0);
    check("R1 number", {28'b0, irqNum}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pswWrEn = VECS[v].wr; pswWrData = VECS[v].wd; takeIrq = VECS[v].ti;
      takeExc = VECS[v].te; excCause = VECS[v].cause; retExc = VECS[v].rt;
      irqReq = VECS[v].req; userMiss = VECS[v].um;
      @(posedge clk); #2;
      check($sformatf("R4-R11 psw row %0d", v), psw, VECS[v].expPsw);
      check($sformatf("R2 trigger row %0d", v), {31'b0, irqTrigger}, {31'b0, VECS[v].expTrig});
      check($sformatf("R3 number row %0d", v), {28'b0, irqNum}, {28'b0, VECS[v].expNum});
      check($sformatf("R9 address row %0d", v), handlerAddr, VECS[v].expAddr);
    end

    // R3 walking request over an open mask, line 0 always present
    @(negedge clk); idleIn(); pswWrEn = 1'b1; pswWrData = 32'h0100_FFFF; irqReq = '0;
    @(negedge clk); idleIn();
    for (int i = 0; i < 16; i++) begin
      irqReq = 16'(1 << i) | 16'h0001;
      #1;
      check($sformatf("R3 walk line %0d", i), {28'b0, irqNum}, i);
      check($sformatf("R2 walk trigger %0d", i), {31'b0, irqTrigger}, 32'h1);
    end

    // R2 R3 mask closed hides every request
    @(negedge clk); pswWrEn = 1'b1; pswWrData = 32'h0100_0000; irqReq = 16'hFFFF;
    @(negedge clk); idleIn(); #1;
    check("R2 masked trigger", {31'b0, irqTrigger}, 32'h0);
    check("R3 masked number", {28'b0, irqNum}, 32'h0);

    // R1 reset mid-run
    rstN = 1'b0;
    @(posedge clk); #2;
    check("R1 psw after reset", psw, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule